// File: doc/BRIEF.md
# BCD Centisecond Watchdog Timer

This block supervises a processor by counting down a programmable timeout and flagging when software has failed to service it in time. The timeout is written as two packed-BCD bytes: the low byte carries tenths (bits 7:4) and hundredths (bits 3:0) of a second, and the high byte carries tens of seconds (bits 7:4) and seconds (bits 3:0). The count therefore runs from 0.01 s to 99.99 s in 10 ms steps. A 100 Hz tick input from elsewhere in the chip paces the count. Software services the watchdog by rewriting either timeout byte, which reloads the counter and starts a fresh period.

When the counter expires, the watchdog flag is raised even if the watchdog is disabled. A control write sets an enable bit and a mode bit. In interrupt mode (mode 0) an enabled timeout also raises an interrupt request, and the counter keeps reloading so that expiries repeat. In reset mode (mode 1) an enabled timeout raises a reset request for a fixed number of ticks, and the enable bit clears itself when that pulse ends. A stored timeout of zero in both bytes stops the watchdog. The timeout bytes are not cleared by reset. The counter stays idle until software writes a timeout byte.

Top module: `bcd_watchdog`

## Requirements
- R1: After a synchronous reset, flag_o, irq_o, rst_req_o and en_o are all 0. Ticks have no effect until at least one timeout byte has been written.
- R2: With stored timeout N (four BCD digits, hi byte then lo byte), flag_o rises on the clock edge of the N-th tick after the last reload, and not earlier.
- R3: The count borrows across all four BCD digits, so values such as 0100, 0206 and 1000 expire after exactly 100, 206 and 1000 ticks.
- R4: A write to either timeout byte reloads the counter and restarts the period. A write in the same cycle as an expiring tick suppresses that expiry.
- R5: An expiry sets flag_o even when en_o is 0. In that case irq_o and rst_req_o stay 0.
- R6: With en_o=1 and mode 0, an expiry sets flag_o and irq_o together. The counter reloads, and a further expiry after another N ticks raises irq_o again.
- R7: flag_o and irq_o clear on a flag read strobe or on a flag write with data 0. A flag write with data 1 leaves them unchanged. An expiry in the same cycle as a clear leaves flag_o set.
- R8: With en_o=1 and mode 1, an expiry raises rst_req_o for RST_TICKS ticks. en_o falls to 0 on the edge where rst_req_o falls, and later expiries raise no reset.
- R9: With both timeout bytes 00h, the watchdog never expires, whatever the number of ticks.
- R10: flag_o rises only on a clock edge at which tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 100 Hz count enable, one cycle wide |
| lo_wr_i | input | 1 | Write strobe, low timeout byte |
| hi_wr_i | input | 1 | Write strobe, high timeout byte |
| wdata_i | input | REG_W | Timeout byte write data (packed BCD) |
| ctl_wr_i | input | 1 | Write strobe for enable and mode |
| ctl_en_i | input | 1 | Enable value to write |
| ctl_mode_i | input | 1 | Mode to write: 0 interrupt, 1 reset pulse |
| flag_rd_i | input | 1 | Flag register read strobe (clears flag) |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data; 0 clears |
| flag_o | output | 1 | Watchdog timeout flag |
| irq_o | output | 1 | Interrupt request contribution |
| rst_req_o | output | 1 | Reset pulse request |
| en_o | output | 1 | Current enable bit |

## Verification
The interesting collision is a service write landing on the same clock edge as the tick that would otherwise expire the count. The bench lets a five-tick timeout run four ticks. It then raises the tick and a low-byte write together, and expects the flag to stay low and a full new period to be needed. A second collision, where a flag read strobe coincides with an expiring tick, is judged by requiring the flag to stay set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    WD_MODE_IRQ = 1'b0,
    WD_MODE_RST = 1'b1
  } wd_mode_e;
endpackage

// File: rtl/wdt_bcd_dec.sv
// Combinational packed-BCD decrement by one, with digit-to-digit borrow.
module wdt_bcd_dec #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val_i,
  output logic [4*DIGITS-1:0] dec_o,
  output logic                zero_o
);
  logic [DIGITS-1:0] brw;
  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] d;
    assign d = val_i[4*g +: 4];
    assign dec_o[4*g +: 4] = !brw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (g < DIGITS - 1) begin : g_chain
      assign brw[g+1] = brw[g] && (d == 4'd0);
    end
  end

  assign zero_o = (dec_o == '0);
endmodule

// File: rtl/wdt_pulse.sv
// Tick-counted pulse generator for the reset request.
module wdt_pulse #(
  parameter int LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic start_i,
  output logic active_o,
  output logic end_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign end_o    = act_q && tick_i && (cnt_q == CW'(1));
  assign active_o = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= CW'(LEN);
    end else if (act_q && tick_i) begin
      if (cnt_q == CW'(1)) act_q <= 1'b0;
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
  import wdt_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int RST_TICKS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             lo_wr_i,
  input  logic             hi_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ctl_wr_i,
  input  logic             ctl_en_i,
  input  logic             ctl_mode_i,
  input  logic             flag_rd_i,
  input  logic             flag_wr_i,
  input  logic             flag_wdata_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             en_o
);
  localparam int CNT_W  = 2 * REG_W;
  localparam int DIGITS = CNT_W / 4;

  logic [REG_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic             armed_q, load, run, dec_zero, timeout;
  logic             en_q, flag_q, irq_q, clr;
  wd_mode_e         mode_q;
  logic             pulse_start, pulse_end, pulse_act;

  assign lo_n    = lo_wr_i ? wdata_i : lo_q;
  assign hi_n    = hi_wr_i ? wdata_i : hi_q;
  assign load    = lo_wr_i || hi_wr_i;
  assign run     = armed_q && ({hi_q, lo_q} != '0) && tick_i && !load;
  assign timeout = run && dec_zero;
  assign clr     = flag_rd_i || (flag_wr_i && !flag_wdata_i);

  wdt_bcd_dec #(.DIGITS(DIGITS)) u_dec (
    .val_i (cnt_q),
    .dec_o (cnt_dec),
    .zero_o(dec_zero)
  );

  assign pulse_start = timeout && en_q && (mode_q == WD_MODE_RST);

  wdt_pulse #(.LEN(RST_TICKS)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .start_i (pulse_start),
    .active_o(pulse_act),
    .end_o   (pulse_end)
  );

  // Timeout bytes hold whatever software last wrote; not cleared by reset.
  always_ff @(posedge clk) begin
    if (lo_wr_i) lo_q <= wdata_i;
    if (hi_wr_i) hi_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load) begin
      armed_q <= 1'b1;
      cnt_q   <= {hi_n, lo_n};
    end else if (run) begin
      cnt_q <= dec_zero ? {hi_q, lo_q} : cnt_dec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= WD_MODE_IRQ;
    end else if (ctl_wr_i) begin
      en_q   <= ctl_en_i;
      mode_q <= wd_mode_e'(ctl_mode_i);
    end else if (pulse_end) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (timeout) begin
      flag_q <= 1'b1;
      if (en_q && (mode_q == WD_MODE_IRQ)) irq_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = pulse_act;
  assign en_o      = en_q;
endmodule

// File: rtl/bcd_watchdog_chk.sv
module bcd_watchdog_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             lo_wr_i,
  input logic             hi_wr_i,
  input logic             ctl_wr_i,
  input logic             flag_o,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             en_o,
  input logic             mode_q,
  input logic [REG_W-1:0] lo_q,
  input logic [REG_W-1:0] hi_q
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!flag_o && !irq_o && !rst_req_o && !en_o));

  // R4
  a_r4_write_blocks_expiry: assert property (@(posedge clk) disable iff (rst)
    (lo_wr_i || hi_wr_i) |=> !$rose(flag_o));

  // R6
  a_r6_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);

  // R8
  a_r8_pulse_needs_reset_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(en_o && mode_q));

  // R8
  a_r8_enable_self_clears: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_req_o) && !$past(ctl_wr_i)) |-> !en_o);

  // R9
  a_r9_zero_never_expires: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past((lo_q != '0) || (hi_q != '0)));

  // R10
  a_r10_expiry_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(tick_i));
endmodule

bind bcd_watchdog bcd_watchdog_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_i   (tick_i),
  .lo_wr_i  (lo_wr_i),
  .hi_wr_i  (hi_wr_i),
  .ctl_wr_i (ctl_wr_i),
  .flag_o   (flag_o),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o),
  .en_o     (en_o),
  .mode_q   (mode_q),
  .lo_q     (lo_q),
  .hi_q     (hi_q)
);

// File: tb/bcd_watchdog_tb.sv
module bcd_watchdog_tb;
  localparam int REG_W = 8;
  localparam int RSTT  = 3;
  localparam int NV    = 8;
  // {hi byte, lo byte, expected tick count}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h01, 16'd1},   {8'h00, 8'h09, 16'd9},
    {8'h00, 8'h10, 16'd10},  {8'h00, 8'h99, 16'd99},
    {8'h01, 8'h00, 16'd100}, {8'h01, 8'h23, 16'd123},
    {8'h02, 8'h06, 16'd206}, {8'h10, 8'h00, 16'd1000}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic lo_wr = 0, hi_wr = 0, ctl_wr = 0, ctl_en = 0, ctl_mode = 0;
  logic flag_rd = 0, flag_wr = 0, flag_wd = 0;
  logic [REG_W-1:0] wdata = '0;
  logic flag, irq, rreq, en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bcd_watchdog #(.REG_W(REG_W), .RST_TICKS(RSTT)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .lo_wr_i(lo_wr), .hi_wr_i(hi_wr),
    .wdata_i(wdata), .ctl_wr_i(ctl_wr), .ctl_en_i(ctl_en), .ctl_mode_i(ctl_mode),
    .flag_rd_i(flag_rd), .flag_wr_i(flag_wr), .flag_wdata_i(flag_wd),
    .flag_o(flag), .irq_o(irq), .rst_req_o(rreq), .en_o(en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wr_lo(input logic [7:0] d);
    lo_wr = 1'b1; wdata = d; @(negedge clk); lo_wr = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] d);
    hi_wr = 1'b1; wdata = d; @(negedge clk); hi_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic e, input logic m);
    ctl_wr = 1'b1; ctl_en = e; ctl_mode = m; @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic rd_flag();
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic wr_flag(input logic d);
    flag_wr = 1'b1; flag_wd = d; @(negedge clk); flag_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state and no counting before the first write
    chk("R1 flag", flag, 0); chk("R1 irq", irq, 0);
    chk("R1 rst_req", rreq, 0); chk("R1 en", en, 0);
    tick_n(5);
    chk("R1 unarmed", flag, 0);

    // R2/R3/R5: table of timeout values, watchdog disabled
    for (int v = 0; v < NV; v++) begin
      wr_hi(VEC[v][31:24]);
      wr_lo(VEC[v][23:16]);
      rd_flag();
      tick_n(int'(VEC[v][15:0]) - 1);
      chk("R2 early", flag, 0);
      tick_n(1);
      chk("R3 expiry", flag, 1);
      chk("R5 no irq when disabled", irq, 0);
    end

    // R4: service write collides with expiring tick
    wr_hi(8'h00); wr_lo(8'h05); rd_flag();
    tick_n(4);
    tick = 1'b1; lo_wr = 1'b1; wdata = 8'h05; @(negedge clk);
    tick = 1'b0; lo_wr = 1'b0; @(negedge clk);
    chk("R4 collision", flag, 0);
    tick_n(4);
    chk("R4 restarted", flag, 0);
    tick_n(1);
    chk("R4 new period", flag, 1);

    // R7: clear rules
    wr_lo(8'h02); rd_flag();
    chk("R7 read clears", flag, 0);
    tick_n(1);
    tick = 1'b1; flag_rd = 1'b1; @(negedge clk);
    tick = 1'b0; flag_rd = 1'b0; @(negedge clk);
    chk("R7 set wins", flag, 1);
    wr_flag(1'b1);
    chk("R7 write one", flag, 1);
    wr_flag(1'b0);
    chk("R7 write zero", flag, 0);

    // R6: interrupt mode, repetitive
    wr_ctl(1'b1, 1'b0);
    wr_lo(8'h03); rd_flag();
    tick_n(2);
    chk("R6 irq early", irq, 0);
    tick_n(1);
    chk("R6 irq", irq, 1); chk("R6 flag", flag, 1);
    rd_flag();
    chk("R7 irq clears", irq, 0);
    tick_n(3);
    chk("R6 irq repeats", irq, 1);
    rd_flag();

    // R8: reset-pulse mode
    wr_ctl(1'b1, 1'b1);
    wr_lo(8'h02); rd_flag();
    tick_n(1);
    chk("R8 before", rreq, 0);
    tick_n(1);
    chk("R8 pulse", rreq, 1); chk("R8 en held", en, 1);
    tick_n(RSTT - 1);
    chk("R8 pulse held", rreq, 1);
    tick_n(1);
    chk("R8 pulse end", rreq, 0); chk("R8 en cleared", en, 0);
    tick_n(2);
    chk("R8 no second pulse", rreq, 0);
    chk("R5 flag while disabled", flag, 1);

    // R9: zero value disables
    wr_hi(8'h00); wr_lo(8'h00); rd_flag();
    tick_n(150);
    chk("R9 zero", flag, 0);

    // R10: no tick, no progress
    wr_lo(8'h01); rd_flag();
    repeat (20) @(negedge clk);
    chk("R10 no tick", flag, 0);
    tick_n(1);
    chk("R10 tick", flag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule